// File: doc/BRIEF.md
# Byte-Addressed Store with 32-bit Single-Error Correction

This block holds a small array of 32-bit words. Each word is kept as a 38-bit codeword that carries 6 check bits of a Hamming code. Reads are byte-wide. Before the addressed byte is returned, the codeword is checked and any single flipped bit is repaired. A one-cycle flag reports a repaired word, and a separate flag reports a syndrome that names no valid position.

A whole-word write encodes the word and stores it in one cycle. A byte write cannot change only one byte, because the check bits cover all four. The block therefore runs a read-modify-write: it fetches the stored codeword, corrects it, merges the new byte into its lane, encodes the result and writes all four bytes back with fresh check bits. A fault-injection input toggles one stored codeword bit, so the correction path can be exercised through the ports.

Control is a four-state machine:
- `ST_IDLE` accepts requests.
- `ST_IDLE -> ST_READ` on a read.
- `ST_IDLE -> ST_FETCH` on a byte write.
- `ST_READ -> ST_IDLE` always, after returning the byte.
- `ST_FETCH -> ST_WRITE` always, after latching the corrected word.
- `ST_WRITE -> ST_IDLE` always, after the write-back.
- A word write or a fault injection is handled inside `ST_IDLE` and leaves the state unchanged.

Top module: `ecc32_rmw_mem`

## Requirements
- R1: During and after reset, `busy`, `rvalid`, `corrected` and `uncorrectable` are low, and every stored word is the all-zero codeword, so it reads back as 0 with no flag.
- R2: Codeword positions run from 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bit i goes to the i-th remaining position in ascending order. The check bit at position 2^k is the XOR of all data positions whose index has bit k set.
- R3: The word index is `addr[AW-1:2]`. `addr[1:0]` selects the lane, and lane n is data bits 8n+7..8n.
- R4: A read accepted in `ST_IDLE` raises `busy` for one cycle. `rdata` and a one-cycle `rvalid` appear after the second rising edge that follows the request.
- R5: After any single codeword bit in positions 1..38 has been flipped, a read returns the original byte and pulses `corrected` with `rvalid`. A read does not rewrite the store.
- R6: If the syndrome is between 39 and 63, the read returns the data bits as stored, with no change, and pulses `uncorrectable` but not `corrected`.
- R7: A byte write holds `busy` high for exactly two cycles. It changes only its own lane and rewrites the word with fresh check bits, so an earlier single-bit fault is cleared.
- R8: During a byte write, `corrected` or `uncorrectable` reports the fetched word one cycle after the request has been accepted.
- R9: A byte write to a word whose syndrome is uncorrectable writes nothing back, and the stored codeword stays as it was.
- R10: A word write takes one cycle, keeps `busy` low, ignores `addr[1:0]` and raises no flag.
- R11: In `ST_IDLE` exactly one request is taken per cycle, in this priority: read, byte write, word write, injection. While `busy` is high, every request is ignored.
- R12: An `inj` with `inj_pos` from 1 to 38 toggles that codeword bit of the addressed word. An `inj_pos` of 0 or above 38 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (6) | Byte address |
| rd | input | 1 | Read request |
| wr_byte | input | 1 | Byte write request (read-modify-write) |
| wdata | input | 8 | Byte to write |
| wr_word | input | 1 | Whole-word write request |
| wword | input | 32 | Word to write |
| inj | input | 1 | Fault-injection request |
| inj_pos | input | 6 | Codeword position to toggle |
| busy | output | 1 | A read or a read-modify-write is in progress |
| rvalid | output | 1 | `rdata` is valid in this cycle |
| rdata | output | 8 | Read byte |
| corrected | output | 1 | One-cycle pulse: a single-bit error was repaired |
| uncorrectable | output | 1 | One-cycle pulse: the syndrome points outside the codeword |

## Verification
Properties are checked on every cycle:
- a read gives `rvalid` two edges later, and that `rvalid` lasts one cycle;
- a byte write holds `busy` for exactly two cycles;
- a word write never raises `busy`;
- the two flags never rise together and only follow a busy cycle;
- the store never sees a write and an injection together.

Only the bench scenarios can show the rest:
- the codeword layout, by injecting each of the 38 positions in turn;
- repair of each of those faults;
- lane merging;
- scrubbing by a read-modify-write;
- suppressed write-back on an uncorrectable word;
- request priority, and injections with out-of-range positions that change nothing.

// File: rtl/ecc32_pkg.sv
package ecc32_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_FETCH,
        ST_WRITE
    } ecc_state_e;

    // Positions that are powers of two carry check bits.
    function automatic bit is_chk_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Data bit index held at a non-check position.
    function automatic int data_slot(int p);
        return p - 1 - $clog2(p + 1);
    endfunction

    // Positions 1..npos whose index has bit k set.
    function automatic logic [63:0] cover_mask(int npos, int k, bit with_chk);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p <= npos; p++) begin
            if (((p >> k) & 1) == 1 && (with_chk || !is_chk_pos(p))) begin
                m[p-1] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc32_enc.sv
module ecc32_enc
    import ecc32_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    localparam int NW = DW + CW
) (
    input  logic [DW-1:0] data,
    output logic [NW-1:0] code
);

    logic [NW-1:0] placed;

    for (genvar p = 1; p <= NW; p++) begin : g_pos
        if (is_chk_pos(p)) begin : g_chk
            localparam logic [63:0] MASK = cover_mask(NW, $clog2(p), 1'b0);
            assign placed[p-1] = 1'b0;
            assign code[p-1]   = ^(placed & MASK[NW-1:0]);
        end else begin : g_dat
            assign placed[p-1] = data[data_slot(p)];
            assign code[p-1]   = data[data_slot(p)];
        end
    end

endmodule

// File: rtl/ecc32_dec.sv
module ecc32_dec
    import ecc32_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    localparam int NW = DW + CW
) (
    input  logic [NW-1:0] code,
    output logic [DW-1:0] data,
    output logic [CW-1:0] syn,
    output logic          fixable,
    output logic          broken
);

    logic [NW-1:0] fixed;

    for (genvar k = 0; k < CW; k++) begin : g_syn
        localparam logic [63:0] MASK = cover_mask(NW, k, 1'b1);
        assign syn[k] = ^(code & MASK[NW-1:0]);
    end

    for (genvar p = 1; p <= NW; p++) begin : g_fix
        assign fixed[p-1] = code[p-1] ^ (syn == CW'(p));
        if (!is_chk_pos(p)) begin : g_out
            assign data[data_slot(p)] = fixed[p-1];
        end
    end

    assign fixable = (syn != '0) && (syn <= CW'(NW));
    assign broken  = (syn > CW'(NW));

endmodule

// File: rtl/ecc32_store.sv
module ecc32_store #(
    parameter int WORDS = 16,
    parameter int NW    = 38,
    parameter int PW    = 6,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [NW-1:0] wcode,
    input  logic          flip,
    input  logic [IW-1:0] faddr,
    input  logic [PW-1:0] fpos,
    input  logic [IW-1:0] raddr,
    output logic [NW-1:0] rcode
);

    logic [NW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wcode;
        end else if (flip) begin
            for (int b = 0; b < NW; b++) begin
                if (fpos == PW'(b + 1)) begin
                    mem[faddr][b] <= ~mem[faddr][b];
                end
            end
        end
    end

    assign rcode = mem[raddr];

    // R11: the control never writes and injects in the same cycle
    a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && flip));

endmodule

// File: rtl/ecc32_rmw_mem.sv
module ecc32_rmw_mem
    import ecc32_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IW    = $clog2(WORDS),
    localparam int LANES = DATA_W / BYTE_W,
    localparam int LW    = $clog2(LANES),
    localparam int AW    = IW + LW,
    localparam int NW    = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd,
    input  logic              wr_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wword,
    input  logic              inj,
    input  logic [CHK_W-1:0]  inj_pos,
    output logic              busy,
    output logic              rvalid,
    output logic [BYTE_W-1:0] rdata,
    output logic              corrected,
    output logic              uncorrectable
);

    ecc_state_e state, state_nx;

    logic [IW-1:0]     lat_idx;
    logic [LW-1:0]     lat_lane;
    logic [BYTE_W-1:0] lat_byte;
    logic [DATA_W-1:0] hold_data;
    logic              hold_broken;

    logic [NW-1:0]     st_rcode, enc_code;
    logic [DATA_W-1:0] dec_data, enc_in, merged;
    logic [CHK_W-1:0]  dec_syn;
    logic              dec_fix, dec_bad;
    logic [BYTE_W-1:0] lane_v [LANES];

    logic idle, take_rd, take_wb, take_ww, take_inj;

    assign idle     = (state == ST_IDLE);
    assign take_rd  = idle && rd;
    assign take_wb  = idle && !rd && wr_byte;
    assign take_ww  = idle && !rd && !wr_byte && wr_word;
    assign take_inj = idle && !rd && !wr_byte && !wr_word && inj
                      && (inj_pos != '0) && (inj_pos <= CHK_W'(NW));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_rd)      state_nx = ST_READ;
                else if (take_wb) state_nx = ST_FETCH;
            end
            ST_READ:  state_nx = ST_IDLE;
            ST_FETCH: state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid        <= 1'b0;
            rdata         <= '0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
            lat_idx       <= '0;
            lat_lane      <= '0;
            lat_byte      <= '0;
            hold_data     <= '0;
            hold_broken   <= 1'b0;
        end else begin
            rvalid        <= 1'b0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
            if (take_rd || take_wb) begin
                lat_idx  <= addr[AW-1:LW];
                lat_lane <= addr[LW-1:0];
                lat_byte <= wdata;
            end
            unique case (state)
                ST_READ: begin
                    rdata         <= lane_v[lat_lane];
                    rvalid        <= 1'b1;
                    corrected     <= dec_fix;
                    uncorrectable <= dec_bad;
                end
                ST_FETCH: begin
                    hold_data     <= dec_data;
                    hold_broken   <= dec_bad;
                    corrected     <= dec_fix;
                    uncorrectable <= dec_bad;
                end
                default: ;
            endcase
        end
    end

    assign busy = !idle;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_v[l] = dec_data[BYTE_W*l +: BYTE_W];
        assign merged[BYTE_W*l +: BYTE_W] =
            (lat_lane == LW'(l)) ? lat_byte : hold_data[BYTE_W*l +: BYTE_W];
    end

    assign enc_in = (state == ST_WRITE) ? merged : wword;

    ecc32_enc #(.DW(DATA_W), .CW(CHK_W)) u_enc (
        .data (enc_in),
        .code (enc_code)
    );

    ecc32_dec #(.DW(DATA_W), .CW(CHK_W)) u_dec (
        .code    (st_rcode),
        .data    (dec_data),
        .syn     (dec_syn),
        .fixable (dec_fix),
        .broken  (dec_bad)
    );

    ecc32_store #(.WORDS(WORDS), .NW(NW), .PW(CHK_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take_ww || (state == ST_WRITE && !hold_broken)),
        .waddr (take_ww ? addr[AW-1:LW] : lat_idx),
        .wcode (enc_code),
        .flip  (take_inj),
        .faddr (addr[AW-1:LW]),
        .fpos  (inj_pos),
        .raddr (lat_idx),
        .rcode (st_rcode)
    );

    // R4: read data arrives two edges after an accepted read
    a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd) |-> ##2 rvalid);

    // R4: rvalid is a single-cycle pulse
    a_r4_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R7: a byte write keeps busy high for exactly two cycles
    a_r7_rmw_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd && wr_byte) |=> (busy ##1 busy ##1 !busy));

    // R10: a word write never raises busy
    a_r10_word_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd && !wr_byte && wr_word) |=> !busy);

    // R6: the two flags are exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected && uncorrectable));

    // R8: a flag only follows a busy cycle
    a_r8_flag_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (corrected || uncorrectable) |-> $past(busy));

endmodule

// File: tb/sim_ecc32_rmw_mem.sv
module sim_ecc32_rmw_mem;

    localparam int WORDS = 16;
    localparam int AW    = 6;
    localparam int NW    = 38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        rd = 1'b0, wr_byte = 1'b0, wr_word = 1'b0, inj = 1'b0;
    logic [7:0]  wdata = '0;
    logic [31:0] wword = '0;
    logic [5:0]  inj_pos = '0;
    logic        busy, rvalid, corrected, uncorrectable;
    logic [7:0]  rdata;

    always #5 clk = ~clk;

    ecc32_rmw_mem #(.WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr_byte(wr_byte),
        .wdata(wdata), .wr_word(wr_word), .wword(wword), .inj(inj),
        .inj_pos(inj_pos), .busy(busy), .rvalid(rvalid), .rdata(rdata),
        .corrected(corrected), .uncorrectable(uncorrectable)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string req = "R1";

    // Reference model state
    logic [NW:1] mm [WORDS];
    int          phase;
    int          m_idx, m_lane;
    logic [7:0]  m_byte;
    logic [31:0] m_hold;
    bit          m_broken;
    bit          exp_rvalid, exp_corr, exp_unc;
    logic [7:0]  exp_rdata;
    logic [31:0] md;
    bit          mfx, mbk;

    // R2: codeword layout from the requirement
    function automatic logic [NW:1] enc(logic [31:0] d);
        logic [NW:1] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= NW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            bit par;
            par = 1'b0;
            for (int p = 1; p <= NW; p++) begin
                if ((p & (p - 1)) != 0 && ((p >> k) & 1) == 1) par ^= c[p];
            end
            c[1 << k] = par;
        end
        return c;
    endfunction

    task automatic dec(input logic [NW:1] c, output logic [31:0] d,
                       output bit fx, output bit bk);
        int s;
        int j;
        s = 0;
        for (int p = 1; p <= NW; p++) if (c[p]) s ^= p;
        fx = (s != 0) && (s <= NW);
        bk = (s > NW);
        if (fx) c[s] = ~c[s];
        j = 0;
        d = '0;
        for (int p = 1; p <= NW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = c[p];
                j++;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mm[w] = '0;
            phase = 0;
            exp_rvalid = 0; exp_corr = 0; exp_unc = 0;
            exp_rdata = '0;
            m_broken = 0;
        end else begin
            exp_rvalid = 0; exp_corr = 0; exp_unc = 0;
            case (phase)
                0: begin
                    if (rd) begin
                        phase = 1; m_idx = int'(addr >> 2); m_lane = int'(addr & 3);
                    end else if (wr_byte) begin
                        phase = 2; m_idx = int'(addr >> 2); m_lane = int'(addr & 3);
                        m_byte = wdata;
                    end else if (wr_word) begin
                        mm[int'(addr >> 2)] = enc(wword);
                    end else if (inj && inj_pos >= 1 && inj_pos <= NW) begin
                        mm[int'(addr >> 2)][inj_pos] = ~mm[int'(addr >> 2)][inj_pos];
                    end
                end
                1: begin
                    dec(mm[m_idx], md, mfx, mbk);
                    exp_rdata = md[8*m_lane +: 8];
                    exp_rvalid = 1; exp_corr = mfx; exp_unc = mbk;
                    phase = 0;
                end
                2: begin
                    dec(mm[m_idx], md, mfx, mbk);
                    m_hold = md; m_broken = mbk;
                    exp_corr = mfx; exp_unc = mbk;
                    phase = 3;
                end
                default: begin
                    if (!m_broken) begin
                        m_hold[8*m_lane +: 8] = m_byte;
                        mm[m_idx] = enc(m_hold);
                    end
                    phase = 0;
                end
            endcase
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        check("busy", 32'(busy), 32'(phase != 0));
        check("rvalid", 32'(rvalid), 32'(exp_rvalid));
        check("corrected", 32'(corrected), 32'(exp_corr));
        check("uncorrectable", 32'(uncorrectable), 32'(exp_unc));
        if (exp_rvalid) check("rdata", 32'(rdata), 32'(exp_rdata));
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_rd(int a);
        @(negedge clk); addr = AW'(a); rd = 1;
        @(negedge clk); rd = 0;
        settle();
    endtask

    task automatic do_wb(int a, logic [7:0] b);
        @(negedge clk); addr = AW'(a); wdata = b; wr_byte = 1;
        @(negedge clk); wr_byte = 0;
        settle();
    endtask

    task automatic do_ww(int a, logic [31:0] w);
        @(negedge clk); addr = AW'(a); wword = w; wr_word = 1;
        @(negedge clk); wr_word = 0;
        settle();
    endtask

    task automatic do_inj(int a, int pos);
        @(negedge clk); addr = AW'(a); inj_pos = 6'(pos); inj = 1;
        @(negedge clk); inj = 0;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset values compared each cycle while reset is held
        repeat (3) @(negedge clk);
        rst_n = 1;
        do_rd(0);
        do_rd(13);

        // R10: word writes with nonzero low address bits; R4 timing on each read
        req = "R10";
        do_ww(5, 32'hA5C3_0F12);
        do_ww(11, 32'h00FF_1234);
        // R3: each lane of word 1
        req = "R3";
        for (int l = 0; l < 4; l++) do_rd(4 + l);
        do_rd(10);

        // R5 and R2: every single position is repaired, and a read leaves the fault in place
        req = "R5";
        for (int p = 1; p <= NW; p++) begin
            do_inj(4, p);
            do_rd(4 + (p % 4));
            do_rd(4 + ((p + 1) % 4));
            do_inj(4, p);
        end

        // R12: positions outside 1..38 change nothing
        req = "R12";
        do_inj(4, 0);
        do_inj(4, 39);
        do_inj(4, 63);
        do_rd(4);
        do_rd(7);

        // R7: byte merge keeps the other lanes
        req = "R7";
        do_wb(6, 8'h7E);
        for (int l = 0; l < 4; l++) do_rd(4 + l);

        // R8: a fault is flagged during the RMW; R7: the write-back scrubs it
        req = "R8";
        do_inj(4, 10);
        do_wb(4, 8'h11);
        req = "R7";
        do_rd(4);
        do_rd(5);

        // R6: double fault with syndrome 39
        req = "R6";
        do_ww(8, 32'h1234_5678);
        do_inj(8, 32);
        do_inj(8, 7);
        do_rd(9);
        do_rd(11);
        // R9: no write-back on an uncorrectable word
        req = "R9";
        do_wb(8, 8'hEE);
        do_rd(8);
        do_rd(9);

        // R11: simultaneous requests, then a request while busy
        req = "R11";
        @(negedge clk);
        addr = AW'(12); wdata = 8'h55; wword = 32'hDEAD_BEEF;
        rd = 1; wr_byte = 1; wr_word = 1;
        @(negedge clk); rd = 0; wr_byte = 0;
        @(negedge clk); wr_word = 0;
        settle();
        do_rd(12);
        @(negedge clk); addr = AW'(13); wdata = 8'h3C; wr_byte = 1; wr_word = 1;
        @(negedge clk); wr_byte = 0;
        @(negedge clk); rd = 1;
        @(negedge clk); rd = 0; wr_word = 0;
        settle();
        do_rd(12);
        do_rd(13);
        do_rd(14);

        settle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule